// File: doc/BRIEF.md
# Sorted Deviation Merger

This block turns the per-edge candidate lists of one four-edge parity check into a single syndrome stream ordered by reliability. Each edge supplies a list of thirteen (symbol, LLR) entries, already sorted by ascending LLR. Every candidate is found by replacing the head entry (index 0) of one or two edges with a less reliable one. No general sorter is used. Only the one-deviation candidates (indices 1..12 on a single edge) and the two-deviation candidates (indices 1 and 2 on each pair of edges) are produced. Because the lists arrive sorted, the one-deviation candidates come from a four-way merge that walks a pointer per edge. The two-deviation candidates form six small groups of four, one group per edge pair. Each group is put in order by a fixed compare, and a selection stage walks the six group heads.

A frame starts with a `start` pulse while the block is idle. The block registers the flattened lists at that edge. It then presents 73 entries on a valid/ready stream. The first entry is the base syndrome, built only from head entries. The rest follow in non-decreasing LLR. Each entry carries the combined symbol (the XOR of the chosen entries' symbols), the summed LLR and a mask of the deviating edges.

The controller has three states. IDLE waits for `start` (transition IDLE→BASE, which also loads the lists). BASE presents the base syndrome and moves on once it is accepted (BASE→MERGE). MERGE offers the smaller of the two merge heads and returns to idle when the last entry is accepted (MERGE→IDLE).

Top module: `devset_merger`

## Requirements
- R1: After reset, and while reset is asserted, `out_valid` and `out_last` are low.
- R2: On a cycle with `start` high in IDLE, the block registers the lists. Entry k of edge e is taken from `in_sym[(e*13+k)*6 +: 6]` and `in_llr[(e*13+k)*8 +: 8]`. Later changes of the inputs, and any `start` pulse before the frame ends, have no effect on the stream.
- R3: The first entry of each frame has mask 0. Its symbol is the XOR of the four index-0 symbols (base symbol S0). Its LLR is the sum of the four index-0 LLRs (base LLR L0).
- R4: For every edge e and index k in 1..12 there is exactly one entry with that edge deviating. Its symbol is S0 ^ sym[e][0] ^ sym[e][k]. Its LLR is L0 + llr[e][k] - llr[e][0].
- R5: For every edge pair a<b and indices i,j in {1,2} there is exactly one entry. Its symbol is S0 ^ sym[a][0] ^ sym[a][i] ^ sym[b][0] ^ sym[b][j]. Its LLR is L0 plus both LLR increases over the index-0 entries.
- R6: Within a frame, the LLRs of accepted entries never decrease.
- R7: Among equal LLRs, one-deviation entries come before two-deviation entries. One-deviation ties are ordered by lower edge, then lower index. Two-deviation ties are ordered by pair rank (0,1),(0,2),(0,3),(1,2),(1,3),(2,3), then by the (i,j) order (1,1),(1,2),(2,1),(2,2).
- R8: A frame holds exactly 73 entries. `out_last` is high on the last one only. After it is accepted, `out_valid` is low.
- R9: While `out_valid` is high and `out_ready` is low, the entry is held unchanged.
- R10: `out_mask` bit e is set exactly when edge e deviates from its index-0 entry. At most two bits are ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (taken only in IDLE) |
| in_sym | input | 312 | Flattened symbols, 4 edges x 13 entries x 6 bits |
| in_llr | input | 416 | Flattened LLRs, 4 edges x 13 entries x 8 bits, ascending per edge |
| out_valid | output | 1 | Entry available |
| out_ready | input | 1 | Consumer accepts the entry |
| out_sym | output | 6 | Combined symbol of the entry |
| out_llr | output | 10 | Summed LLR of the entry |
| out_mask | output | 4 | Deviating-edge mask |
| out_last | output | 1 | Final entry of the frame |

## Verification
The ordering assertions take for granted that the lists loaded at `start` are sorted ascending per edge. Unsorted lists would make both the merge heads and the local four-entry groups non-monotone. Every bench stimulus builds each list from a head value plus non-negative increments, so it stays sorted. Some increments are zero or one, which creates many exact LLR ties. The bench drives deliberately unsorted data on the inputs only while a frame is streaming, when `start` is ignored, so the loaded copy always stays sorted.

// File: rtl/devset_pkg.sv
package devset_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BASE  = 2'd1,
        ST_MERGE = 2'd2
    } dm_state_e;

    // lower edge of pair number p, pairs enumerated a<b in ascending order
    function automatic int pair_lo(input int p, input int edges);
        int n;
        n = 0;
        pair_lo = 0;
        for (int a = 0; a < edges; a++) begin
            for (int b = a + 1; b < edges; b++) begin
                if (n == p) pair_lo = a;
                n++;
            end
        end
    endfunction

    // upper edge of pair number p
    function automatic int pair_hi(input int p, input int edges);
        int n;
        n = 0;
        pair_hi = 0;
        for (int a = 0; a < edges; a++) begin
            for (int b = a + 1; b < edges; b++) begin
                if (n == p) pair_hi = b;
                n++;
            end
        end
    endfunction

endpackage

// File: rtl/devset_single_merge.sv
// Merge of the one-deviation candidates: one pointer per edge, smallest head wins.
module devset_single_merge #(
    parameter int EDGES    = 4,
    parameter int LIST_LEN = 13,
    parameter int SYM_W    = 6,
    parameter int LLR_W    = 8,
    localparam int COST_W  = LLR_W + 1,
    localparam int EW      = (EDGES > 1) ? $clog2(EDGES) : 1,
    localparam int PW      = $clog2(LIST_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              pop,
    input  logic [SYM_W-1:0]  sym [EDGES][LIST_LEN],
    input  logic [LLR_W-1:0]  llr [EDGES][LIST_LEN],
    output logic              head_valid,
    output logic [COST_W-1:0] head_cost,
    output logic [SYM_W-1:0]  head_delta,
    output logic [EW-1:0]     head_edge
);

    logic [PW-1:0]     ptr_q   [EDGES];
    logic [PW-1:0]     rd_idx  [EDGES];
    logic [EDGES-1:0]  live;
    logic [COST_W-1:0] cost    [EDGES];

    always_comb begin
        for (int e = 0; e < EDGES; e++) begin
            live[e]   = (ptr_q[e] < PW'(LIST_LEN));
            rd_idx[e] = live[e] ? ptr_q[e] : '0;
            cost[e]   = {1'b0, llr[e][rd_idx[e]]} - {1'b0, llr[e][0]};
        end
    end

    // strict compare: on equal cost the lower edge keeps the slot
    logic              sel_v;
    logic [COST_W-1:0] sel_cost;
    logic [SYM_W-1:0]  sel_delta;
    logic [EW-1:0]     sel_edge;

    always_comb begin
        sel_v     = 1'b0;
        sel_cost  = '0;
        sel_delta = '0;
        sel_edge  = '0;
        for (int e = 0; e < EDGES; e++) begin
            if (live[e] && (!sel_v || cost[e] < sel_cost)) begin
                sel_v     = 1'b1;
                sel_cost  = cost[e];
                sel_delta = sym[e][0] ^ sym[e][rd_idx[e]];
                sel_edge  = EW'(e);
            end
        end
    end

    assign head_valid = sel_v;
    assign head_cost  = sel_cost;
    assign head_delta = sel_delta;
    assign head_edge  = sel_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < EDGES; e++) ptr_q[e] <= PW'(LIST_LEN);
        end else if (load) begin
            for (int e = 0; e < EDGES; e++) ptr_q[e] <= PW'(1);
        end else if (pop) begin
            ptr_q[sel_edge] <= ptr_q[sel_edge] + 1'b1;
        end
    end

    // R6: sorted lists make the merge head non-decreasing after each pop
    p_single_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !load) |=> (!head_valid || head_cost >= $past(head_cost)));

    // R8: the controller never pops an exhausted merge
    p_single_pop_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/devset_pair_sort.sv
// Orders the four (i,j) combinations of one edge pair, i,j in {1,2}.
module devset_pair_sort #(
    parameter int SYM_W  = 6,
    parameter int COST_W = 9
) (
    input  logic [COST_W-1:0]        a1_cost,
    input  logic [COST_W-1:0]        a2_cost,
    input  logic [COST_W-1:0]        b1_cost,
    input  logic [COST_W-1:0]        b2_cost,
    input  logic [SYM_W-1:0]         a1_delta,
    input  logic [SYM_W-1:0]         a2_delta,
    input  logic [SYM_W-1:0]         b1_delta,
    input  logic [SYM_W-1:0]         b2_delta,
    output logic [3:0][COST_W-1:0]   srt_cost,
    output logic [3:0][SYM_W-1:0]    srt_delta
);

    logic [COST_W-1:0] c11, c12, c21, c22;

    always_comb begin
        c11 = a1_cost + b1_cost;
        c12 = a1_cost + b2_cost;
        c21 = a2_cost + b1_cost;
        c22 = a2_cost + b2_cost;
        // (1,1) is never above either middle term and (2,2) never below
        srt_cost[0]  = c11;
        srt_delta[0] = a1_delta ^ b1_delta;
        srt_cost[3]  = c22;
        srt_delta[3] = a2_delta ^ b2_delta;
        if (c12 <= c21) begin
            srt_cost[1]  = c12;
            srt_delta[1] = a1_delta ^ b2_delta;
            srt_cost[2]  = c21;
            srt_delta[2] = a2_delta ^ b1_delta;
        end else begin
            srt_cost[1]  = c21;
            srt_delta[1] = a2_delta ^ b1_delta;
            srt_cost[2]  = c12;
            srt_delta[2] = a1_delta ^ b2_delta;
        end
    end

endmodule

// File: rtl/devset_pair_merge.sv
// Two-deviation stream: per-pair sorted groups, lowest head chosen each pop.
module devset_pair_merge #(
    parameter int EDGES    = 4,
    parameter int LIST_LEN = 13,
    parameter int SYM_W    = 6,
    parameter int LLR_W    = 8,
    localparam int COST_W  = LLR_W + 1,
    localparam int NPAIR   = EDGES * (EDGES - 1) / 2,
    localparam int GROUP   = 4,
    localparam int PSEL_W  = (NPAIR > 1) ? $clog2(NPAIR) : 1,
    localparam int GP_W    = $clog2(GROUP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              pop,
    input  logic [SYM_W-1:0]  sym [EDGES][LIST_LEN],
    input  logic [LLR_W-1:0]  llr [EDGES][LIST_LEN],
    output logic              head_valid,
    output logic [COST_W-1:0] head_cost,
    output logic [SYM_W-1:0]  head_delta,
    output logic [EDGES-1:0]  head_mask
);

    logic [NPAIR-1:0][GROUP-1:0][COST_W-1:0] grp_cost;
    logic [NPAIR-1:0][GROUP-1:0][SYM_W-1:0]  grp_delta;
    logic [NPAIR-1:0][EDGES-1:0]             grp_mask;
    logic [GP_W-1:0]                         ptr_q [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int EA = devset_pkg::pair_lo(p, EDGES);
        localparam int EB = devset_pkg::pair_hi(p, EDGES);

        logic [COST_W-1:0] a1c, a2c, b1c, b2c;
        logic [SYM_W-1:0]  a1d, a2d, b1d, b2d;

        assign a1c = {1'b0, llr[EA][1]} - {1'b0, llr[EA][0]};
        assign a2c = {1'b0, llr[EA][2]} - {1'b0, llr[EA][0]};
        assign b1c = {1'b0, llr[EB][1]} - {1'b0, llr[EB][0]};
        assign b2c = {1'b0, llr[EB][2]} - {1'b0, llr[EB][0]};
        assign a1d = sym[EA][0] ^ sym[EA][1];
        assign a2d = sym[EA][0] ^ sym[EA][2];
        assign b1d = sym[EB][0] ^ sym[EB][1];
        assign b2d = sym[EB][0] ^ sym[EB][2];
        assign grp_mask[p] = (EDGES'(1) << EA) | (EDGES'(1) << EB);

        devset_pair_sort #(.SYM_W(SYM_W), .COST_W(COST_W)) i_sort (
            .a1_cost  (a1c),
            .a2_cost  (a2c),
            .b1_cost  (b1c),
            .b2_cost  (b2c),
            .a1_delta (a1d),
            .a2_delta (a2d),
            .b1_delta (b1d),
            .b2_delta (b2d),
            .srt_cost (grp_cost[p]),
            .srt_delta(grp_delta[p])
        );

        // R6: each local group leaves its sorter in ascending order
        p_group_sorted_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_cost[p][0] <= grp_cost[p][1]) && (grp_cost[p][1] <= grp_cost[p][2]) &&
            (grp_cost[p][2] <= grp_cost[p][3]));
    end

    logic              sel_v;
    logic [PSEL_W-1:0] sel;
    logic [COST_W-1:0] sel_cost;
    logic [SYM_W-1:0]  sel_delta;

    // cascade of two-input compares; equal cost keeps the lower pair rank
    always_comb begin
        sel_v     = 1'b0;
        sel       = '0;
        sel_cost  = '0;
        sel_delta = '0;
        for (int p = 0; p < NPAIR; p++) begin
            if (ptr_q[p] < GP_W'(GROUP)) begin
                if (!sel_v || grp_cost[p][ptr_q[p][1:0]] < sel_cost) begin
                    sel_v     = 1'b1;
                    sel       = PSEL_W'(p);
                    sel_cost  = grp_cost[p][ptr_q[p][1:0]];
                    sel_delta = grp_delta[p][ptr_q[p][1:0]];
                end
            end
        end
    end

    assign head_valid = sel_v;
    assign head_cost  = sel_cost;
    assign head_delta = sel_delta;
    assign head_mask  = sel_v ? grp_mask[sel] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPAIR; p++) ptr_q[p] <= GP_W'(GROUP);
        end else if (load) begin
            for (int p = 0; p < NPAIR; p++) ptr_q[p] <= '0;
        end else if (pop) begin
            ptr_q[sel] <= ptr_q[sel] + 1'b1;
        end
    end

    // R8: no pop of an empty two-deviation stream
    p_pair_pop_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R6: head of the pair stream never falls after a pop
    p_pair_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !load) |=> (!head_valid || head_cost >= $past(head_cost)));

endmodule

// File: rtl/devset_merger.sv
module devset_merger #(
    parameter int EDGES    = 4,
    parameter int LIST_LEN = 13,
    parameter int SYM_W    = 6,
    parameter int LLR_W    = 8,
    localparam int SUM_W   = LLR_W + $clog2(EDGES),
    localparam int SYM_BUS = EDGES * LIST_LEN * SYM_W,
    localparam int LLR_BUS = EDGES * LIST_LEN * LLR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SYM_BUS-1:0] in_sym,
    input  logic [LLR_BUS-1:0] in_llr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SYM_W-1:0]   out_sym,
    output logic [SUM_W-1:0]   out_llr,
    output logic [EDGES-1:0]   out_mask,
    output logic               out_last
);
    import devset_pkg::*;

    localparam int COST_W = LLR_W + 1;
    localparam int EW     = (EDGES > 1) ? $clog2(EDGES) : 1;
    localparam int NPAIR  = EDGES * (EDGES - 1) / 2;
    localparam int TOTAL  = 1 + EDGES * (LIST_LEN - 1) + NPAIR * 4;
    localparam int CW     = $clog2(TOTAL + 1);

    dm_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [SUM_W-1:0]  prev_llr_q;
    logic [SYM_W-1:0]  sym_q [EDGES][LIST_LEN];
    logic [LLR_W-1:0]  llr_q [EDGES][LIST_LEN];

    logic              load, fire, pop_one, pop_two, take_one;
    logic              one_v, two_v;
    logic [COST_W-1:0] one_cost, two_cost;
    logic [SYM_W-1:0]  one_delta, two_delta;
    logic [EW-1:0]     one_edge;
    logic [EDGES-1:0]  two_mask;
    logic [SYM_W-1:0]  base_sym;
    logic [SUM_W-1:0]  base_llr;

    assign load = (state_q == ST_IDLE) && start;
    assign fire = out_valid && out_ready;

    // list capture at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < EDGES; e++) begin
                for (int k = 0; k < LIST_LEN; k++) begin
                    sym_q[e][k] <= '0;
                    llr_q[e][k] <= '0;
                end
            end
        end else if (load) begin
            for (int e = 0; e < EDGES; e++) begin
                for (int k = 0; k < LIST_LEN; k++) begin
                    sym_q[e][k] <= in_sym[(e*LIST_LEN+k)*SYM_W +: SYM_W];
                    llr_q[e][k] <= in_llr[(e*LIST_LEN+k)*LLR_W +: LLR_W];
                end
            end
        end
    end

    always_comb begin
        base_sym = '0;
        base_llr = '0;
        for (int e = 0; e < EDGES; e++) begin
            base_sym = base_sym ^ sym_q[e][0];
            base_llr = base_llr + SUM_W'(llr_q[e][0]);
        end
    end

    devset_single_merge #(
        .EDGES(EDGES), .LIST_LEN(LIST_LEN), .SYM_W(SYM_W), .LLR_W(LLR_W)
    ) i_single (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .pop       (pop_one),
        .sym       (sym_q),
        .llr       (llr_q),
        .head_valid(one_v),
        .head_cost (one_cost),
        .head_delta(one_delta),
        .head_edge (one_edge)
    );

    devset_pair_merge #(
        .EDGES(EDGES), .LIST_LEN(LIST_LEN), .SYM_W(SYM_W), .LLR_W(LLR_W)
    ) i_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .pop       (pop_two),
        .sym       (sym_q),
        .llr       (llr_q),
        .head_valid(two_v),
        .head_cost (two_cost),
        .head_delta(two_delta),
        .head_mask (two_mask)
    );

    // fewer deviations wins an LLR tie
    assign take_one = one_v && (!two_v || one_cost <= two_cost);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            prev_llr_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q      <= '0;
                prev_llr_q <= '0;
            end else if (fire) begin
                cnt_q      <= cnt_q + 1'b1;
                prev_llr_q <= out_llr;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_BASE;
            ST_BASE:  if (out_ready) state_d = ST_MERGE;
            ST_MERGE: if (fire && out_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_sym   = '0;
        out_llr   = '0;
        out_mask  = '0;
        pop_one   = 1'b0;
        pop_two   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_BASE: begin
                out_valid = 1'b1;
                out_sym   = base_sym;
                out_llr   = base_llr;
            end
            ST_MERGE: begin
                out_valid = one_v || two_v;
                if (take_one) begin
                    out_sym  = base_sym ^ one_delta;
                    out_llr  = base_llr + SUM_W'(one_cost);
                    out_mask = EDGES'(1) << one_edge;
                    pop_one  = out_ready;
                end else if (two_v) begin
                    out_sym  = base_sym ^ two_delta;
                    out_llr  = base_llr + SUM_W'(two_cost);
                    out_mask = two_mask;
                    pop_two  = out_ready;
                end
            end
            default: begin
            end
        endcase
        out_last = out_valid && (cnt_q == CW'(TOTAL - 1));
    end

    // R9: a stalled entry is held
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) &&
                                      $stable(out_llr) && $stable(out_mask)));

    // R6: accepted LLRs never fall within a frame
    p_llr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && state_q == ST_MERGE) |-> (out_llr >= prev_llr_q));

    // R3: an empty mask appears only on the first entry of a frame
    p_base_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mask == '0) |-> (cnt_q == '0));

    // R10: never more than two deviating edges
    p_mask_weight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_mask) <= 2));

    // R8: the entry count and the merge contents run out together
    p_heads_remain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MERGE) |-> (one_v || two_v));

    // R8: nothing is offered after the final entry is taken
    p_quiet_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_last) |=> !out_valid);

endmodule

// File: tb/test_devset_merger.sv
`timescale 1ns/1ps
module test_devset_merger;
    localparam int EDGES = 4, LIST_LEN = 13, SYM_W = 6, LLR_W = 8;
    localparam int SUM_W = LLR_W + 2;
    localparam int TOTAL = 73;
    localparam int NVEC  = 5;
    // seed, LLR step limit, nonzero heads, stall period
    localparam int unsigned VEC [NVEC][4] = '{
        '{32'd1,    32'd20, 32'd0, 32'd0},
        '{32'd7,    32'd1,  32'd0, 32'd3},
        '{32'd99,   32'd0,  32'd0, 32'd0},
        '{32'd1234, 32'd5,  32'd1, 32'd2},
        '{32'd42,   32'd3,  32'd0, 32'd5}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
    logic [EDGES*LIST_LEN*SYM_W-1:0] in_sym = '0;
    logic [EDGES*LIST_LEN*LLR_W-1:0] in_llr = '0;
    logic              out_valid, out_last;
    logic [SYM_W-1:0]  out_sym;
    logic [SUM_W-1:0]  out_llr;
    logic [EDGES-1:0]  out_mask;

    int total = 0, fails = 0;
    int lst_sym [EDGES][LIST_LEN];
    int lst_llr [EDGES][LIST_LEN];
    int ex_sym [TOTAL], ex_llr [TOTAL], ex_mask [TOTAL], ex_nd [TOTAL], ex_rk [TOTAL];
    int ex_n;
    int unsigned lcg;

    always #2 clk = ~clk;

    devset_merger i_devset_merger (
        .clk(clk), .rst_n(rst_n), .start(start), .in_sym(in_sym), .in_llr(in_llr),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
        .out_llr(out_llr), .out_mask(out_mask), .out_last(out_last)
    );

    function automatic int unsigned next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg >> 16;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic build_lists(input int unsigned seed, input int unsigned step,
                               input int unsigned nz_head);
        lcg = seed;
        for (int e = 0; e < EDGES; e++) begin
            int l;
            l = (nz_head != 0) ? int'(next_rand() % 21) : 0;
            for (int k = 0; k < LIST_LEN; k++) begin
                if (k > 0) l = l + int'(next_rand() % (step + 1));
                lst_llr[e][k] = l;
                lst_sym[e][k] = int'(next_rand() % 64);
            end
        end
    endtask

    task automatic pack_inputs();
        for (int e = 0; e < EDGES; e++) begin
            for (int k = 0; k < LIST_LEN; k++) begin
                in_sym[(e*LIST_LEN+k)*SYM_W +: SYM_W] = SYM_W'(lst_sym[e][k]);
                in_llr[(e*LIST_LEN+k)*LLR_W +: LLR_W] = LLR_W'(lst_llr[e][k]);
            end
        end
    endtask

    function automatic bit goes_before(input int la, input int na, input int ra,
                                       input int lb, input int nb, input int rb);
        if (la != lb) return la < lb;
        if (na != nb) return na < nb;
        return ra < rb;
    endfunction

    task automatic add_exp(input int s, input int l, input int m, input int nd, input int rk);
        int pos;
        pos = ex_n;
        while (pos > 0 && goes_before(l, nd, rk, ex_llr[pos-1], ex_nd[pos-1], ex_rk[pos-1])) begin
            ex_sym[pos]  = ex_sym[pos-1];
            ex_llr[pos]  = ex_llr[pos-1];
            ex_mask[pos] = ex_mask[pos-1];
            ex_nd[pos]   = ex_nd[pos-1];
            ex_rk[pos]   = ex_rk[pos-1];
            pos--;
        end
        ex_sym[pos] = s; ex_llr[pos] = l; ex_mask[pos] = m; ex_nd[pos] = nd; ex_rk[pos] = rk;
        ex_n++;
    endtask

    task automatic build_expected();
        int s0, l0, p;
        s0 = 0; l0 = 0; ex_n = 0; p = 0;
        for (int e = 0; e < EDGES; e++) begin
            s0 = s0 ^ lst_sym[e][0];
            l0 = l0 + lst_llr[e][0];
        end
        add_exp(s0, l0, 0, 0, 0);
        for (int e = 0; e < EDGES; e++)
            for (int k = 1; k < LIST_LEN; k++)
                add_exp(s0 ^ lst_sym[e][0] ^ lst_sym[e][k],
                        l0 + lst_llr[e][k] - lst_llr[e][0], 1 << e, 1, e*16 + k);
        for (int a = 0; a < EDGES; a++) begin
            for (int b = a + 1; b < EDGES; b++) begin
                for (int c = 0; c < 4; c++) begin
                    int i, j;
                    i = (c < 2) ? 1 : 2;
                    j = (c % 2 == 0) ? 1 : 2;
                    add_exp(s0 ^ lst_sym[a][0] ^ lst_sym[a][i] ^ lst_sym[b][0] ^ lst_sym[b][j],
                            l0 + lst_llr[a][i] - lst_llr[a][0] + lst_llr[b][j] - lst_llr[b][0],
                            (1 << a) | (1 << b), 2, p*4 + c);
                end
                p++;
            end
        end
    endtask

    task automatic run_frame(input int unsigned stall, input bit disturb);
        int idx, cyc, prev, h_sym, h_llr, h_mask;
        bit held, rdy;
        string tag;
        pack_inputs();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        in_sym = ~in_sym;          // R2: post-start changes must not matter
        in_llr = ~in_llr;
        idx = 0; cyc = 0; prev = -1; held = 1'b0; h_sym = 0; h_llr = 0; h_mask = 0;
        while (idx < TOTAL && cyc < 3000) begin
            if (held)
                check(out_valid && int'(out_sym) == h_sym && int'(out_llr) == h_llr &&
                      int'(out_mask) == h_mask, "R9", "stalled entry held",
                      int'(out_llr), h_llr);
            rdy = (stall == 0) || (cyc % stall != 0);
            out_ready = rdy;
            start = (disturb && idx == 20);   // R2: ignored while streaming
            if (out_valid && rdy) begin
                tag = (ex_nd[idx] == 0) ? "R3" : (ex_nd[idx] == 1) ? "R4" : "R5";
                check(int'(out_sym) == ex_sym[idx], tag, "symbol", int'(out_sym), ex_sym[idx]);
                check(int'(out_llr) == ex_llr[idx], tag, "llr", int'(out_llr), ex_llr[idx]);
                check(int'(out_mask) == ex_mask[idx], "R10", "mask", int'(out_mask), ex_mask[idx]);
                check(out_last == (idx == TOTAL - 1), "R8", "last flag", int'(out_last),
                      int'(idx == TOTAL - 1));
                check(int'(out_llr) >= prev, "R6", "non-decreasing llr", int'(out_llr), prev);
                if (idx > 0 && ex_llr[idx] == ex_llr[idx-1])
                    check(int'(out_mask) == ex_mask[idx], "R7", "tie order mask",
                          int'(out_mask), ex_mask[idx]);
                prev = int'(out_llr);
                idx++;
            end
            held = out_valid && !rdy;
            h_sym = int'(out_sym); h_llr = int'(out_llr); h_mask = int'(out_mask);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        check(idx == TOTAL, "R8", "entries in frame", idx, TOTAL);
        check(!out_valid, "R8", "valid after last", int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL R8 watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid, "R1", "valid in reset", int'(out_valid), 0);
        check(!out_last, "R1", "last in reset", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "valid after reset", int'(out_valid), 0);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            build_lists(VEC[v][0], VEC[v][1], VEC[v][2]);
            build_expected();
            run_frame(VEC[v][3], v == 1);
        end

        // R2: without start the block stays quiet
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        check(!out_valid, "R2", "no frame without start", int'(out_valid), 0);
        out_ready = 1'b0;

        // R1: reset in mid frame, then a clean frame
        build_lists(555, 10, 0);
        build_expected();
        pack_inputs();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; out_ready = 1'b1;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!out_valid, "R1", "valid during mid-frame reset", int'(out_valid), 0);
        check(!out_last, "R1", "last during mid-frame reset", int'(out_last), 0);
        out_ready = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "idle after mid-frame reset", int'(out_valid), 0);
        run_frame(4, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule